// File: doc/BRIEF.md
# Constant-Time Modular Exponentiator

This block raises an unsigned base to an unsigned exponent modulo an unsigned modulus. All operands are `WIDTH` bits wide, 32 by default. A caller drives the base, exponent and modulus and pulses `start_i`. The block raises `busy_o` while it works. When the result is ready it pulses `done_o` for one cycle and presents the result on `s_o`, where it stays until the next run finishes.

The run does not depend on the key bits or the operand values. The exponent is scanned from its top bit to its bottom bit. For each bit the accumulator is squared, and then a multiply by the base is always performed. The product of that multiply is written back only when the bit is 1; a multiplexer makes that choice, and no state is skipped.

Every modular product comes from one shared bit-serial unit. It doubles, conditionally adds and reduces once per clock. It always takes one load cycle plus `WIDTH` step cycles. The caller must keep the base below the modulus and keep the modulus above 1.

Top module: `ctexp_engine`

## Requirements
- R1: While `rst_n` is low, and after it is released, `busy_o` and `done_o` are 0 and `s_o` is 0 until a run completes. Asserting reset in the middle of a run aborts that run.
- R2: When base < modulus and modulus > 1, the value on `s_o` at `done_o` equals base^exponent mod modulus. An exponent of 0 gives 1.
- R3: Count the clock edge that samples an accepted start as edge 0. `done_o` goes high just after edge 2·WIDTH·(WIDTH+1)+1, which is 2113 for WIDTH = 32, for any operand values.
- R4: `done_o` stays high for exactly one cycle per run.
- R5: `busy_o` is 1 from the edge that accepts a start until the edge that raises `done_o`. It is 0 in the cycle where `done_o` is high.
- R6: A `start_i` pulse while `busy_o` is 1 is ignored. The running computation keeps its result and its latency.
- R7: `s_o` changes only at the edge that raises `done_o`. It holds its previous value between runs and throughout a new run.
- R8: Each modular multiply takes exactly WIDTH+1 cycles from load to completion, and its product is below the modulus.
- R9: Every run issues exactly 2·WIDTH multiplies. After each multiply by the base, the controller returns to squaring whatever the exponent bit is.
- R10: Base, exponent and modulus are captured only on an accepted start. Changing them while `busy_o` is 1 has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request; accepted only when idle |
| m_i | input | WIDTH | Base; must be below the modulus |
| d_i | input | WIDTH | Exponent |
| n_i | input | WIDTH | Modulus; must be greater than 1 |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| s_o | output | WIDTH | Result, held until the next completion |

## Verification
Assertions are checked on every cycle. They cover the single-cycle completion pulse, the fixed run length against a cycle counter, the per-multiply length and the range of each product, the count of 2·WIDTH multiplies per run, the return to squaring after every multiply by the base, the holding of the result register between completions, and the input latches during a run. Some behaviour only the bench scenarios can show. These are the numerical correctness of the result against an independently computed power, and the fact that latency is the same across very different exponents (all zeros, all ones, a single top bit). The bench also shows that injected start pulses and changed operands during a run leave the answer untouched, and that reset in the middle of a run aborts it cleanly.

// File: rtl/ctexp_pkg.sv
package ctexp_pkg;

  // Controller phases of one exponentiation run.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_SQR  = 2'd2,
    ST_MUL  = 2'd3
  } ctexp_state_e;

endpackage

// File: rtl/ctexp_modmul.sv
// Bit-serial interleaved modular multiplier: product = a * b mod n.
// One load cycle, then WIDTH step cycles, each doing double-reduce and
// add-reduce; both branches are always computed and a mux picks one.
module ctexp_modmul #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] n_i,
  output logic             done_o,
  output logic [WIDTH-1:0] prod_o
);

  localparam int CW = $clog2(WIDTH + 1);

  logic [WIDTH-1:0] a_q, a_n;
  logic [WIDTH-1:0] b_q, b_n;
  logic [WIDTH-1:0] n_q, n_n;
  logic [WIDTH-1:0] acc_q, acc_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic             run_q, run_n;
  logic             done_q, done_n;
  logic             en;

  logic [WIDTH:0]   dbl, sum;
  logic [WIDTH-1:0] dbl_red, sum_red, step;

  // Datapath: both reduction paths evaluated every cycle.
  always_comb begin
    dbl     = {acc_q, 1'b0};
    dbl_red = (dbl >= {1'b0, n_q}) ? WIDTH'(dbl - {1'b0, n_q}) : dbl[WIDTH-1:0];
    sum     = {1'b0, dbl_red} + {1'b0, a_q};
    sum_red = (sum >= {1'b0, n_q}) ? WIDTH'(sum - {1'b0, n_q}) : sum[WIDTH-1:0];
    step    = b_q[WIDTH-1] ? sum_red : dbl_red;
  end

  assign en = start_i | run_q;

  always_comb begin
    a_n    = a_q;
    b_n    = b_q;
    n_n    = n_q;
    acc_n  = acc_q;
    cnt_n  = cnt_q;
    run_n  = run_q;
    done_n = 1'b0;
    if (start_i) begin
      a_n   = a_i;
      b_n   = b_i;
      n_n   = n_i;
      acc_n = '0;
      cnt_n = CW'(WIDTH);
      run_n = 1'b1;
    end else if (run_q) begin
      acc_n = step;
      b_n   = {b_q[WIDTH-2:0], 1'b0};
      cnt_n = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_n  = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      n_q   <= '0;
      acc_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (en) begin
      a_q   <= a_n;
      b_q   <= b_n;
      n_q   <= n_n;
      acc_q <= acc_n;
      cnt_q <= cnt_n;
      run_q <= run_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_n;
  end

  assign done_o = done_q;
  assign prod_o = acc_q;

  // Checker counter: cycles since the last load.
  logic [CW:0] chk_cyc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       chk_cyc_q <= '0;
    else if (start_i) chk_cyc_q <= '0;
    else if (run_q)   chk_cyc_q <= chk_cyc_q + 1'b1;
  end

  // R8
  mm_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (chk_cyc_q == (CW+1)'(WIDTH)));

  // R8
  mm_prod_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (prod_o < n_q));

endmodule

// File: rtl/ctexp_keyscan.sv
// Exponent bit scanner: presents bits from the top down, flags the last.
module ctexp_keyscan #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic [WIDTH-1:0] d_i,
  output logic             bit_o,
  output logic             last_o
);

  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic [WIDTH-1:0] d_q, d_n;
  logic [IW-1:0]    idx_q, idx_n;
  logic             en;

  assign en = load_i | adv_i;

  always_comb begin
    d_n   = d_q;
    idx_n = idx_q;
    if (load_i) begin
      d_n   = d_i;
      idx_n = IW'(WIDTH - 1);
    end else if (adv_i) begin
      d_n   = {d_q[WIDTH-2:0], 1'b0};
      idx_n = idx_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q   <= '0;
      idx_q <= '0;
    end else if (en) begin
      d_q   <= d_n;
      idx_q <= idx_n;
    end
  end

  assign bit_o  = d_q[WIDTH-1];
  assign last_o = (idx_q == '0);

  // R9
  scan_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i && !last_o) |=> (idx_q == $past(idx_q) - 1'b1));

endmodule

// File: rtl/ctexp_engine.sv
// Constant-time left-to-right exponentiator: square, always multiply,
// select the kept value with a mux. Reset is asynchronous on assertion;
// its release is expected to be synchronised upstream.
module ctexp_engine #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [WIDTH-1:0] m_i,
  input  logic [WIDTH-1:0] d_i,
  input  logic [WIDTH-1:0] n_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] s_o
);
  import ctexp_pkg::*;

  localparam int LAT = 2 * WIDTH * (WIDTH + 1) + 1;

  ctexp_state_e     state_q, state_n;
  logic [WIDTH-1:0] m_q, m_n;
  logic [WIDTH-1:0] n_q, n_n;
  logic [WIDTH-1:0] s_q, s_n;
  logic [WIDTH-1:0] res_q, res_n;
  logic             done_q, done_n;
  logic             accept;

  logic             mm_start, mm_done;
  logic [WIDTH-1:0] mm_a, mm_b, mm_prod;
  logic             ks_load, ks_adv, ks_bit, ks_last;
  logic [WIDTH-1:0] kept;

  ctexp_modmul #(.WIDTH(WIDTH)) u_modmul (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (mm_start),
    .a_i     (mm_a),
    .b_i     (mm_b),
    .n_i     (n_q),
    .done_o  (mm_done),
    .prod_o  (mm_prod)
  );

  ctexp_keyscan #(.WIDTH(WIDTH)) u_keyscan (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (ks_load),
    .adv_i  (ks_adv),
    .d_i    (d_i),
    .bit_o  (ks_bit),
    .last_o (ks_last)
  );

  assign accept = (state_q == ST_IDLE) && start_i;
  // Data-independent select between the fresh product and the square.
  assign kept   = ks_bit ? mm_prod : s_q;

  always_comb begin
    state_n  = state_q;
    m_n      = m_q;
    n_n      = n_q;
    s_n      = s_q;
    res_n    = res_q;
    done_n   = 1'b0;
    mm_start = 1'b0;
    mm_a     = s_q;
    mm_b     = s_q;
    ks_load  = 1'b0;
    ks_adv   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          m_n     = m_i;
          n_n     = n_i;
          s_n     = WIDTH'(1);
          ks_load = 1'b1;
          state_n = ST_LOAD;
        end
      end
      ST_LOAD: begin
        mm_start = 1'b1;
        state_n  = ST_SQR;
      end
      ST_SQR: begin
        if (mm_done) begin
          s_n      = mm_prod;
          mm_start = 1'b1;
          mm_a     = mm_prod;
          mm_b     = m_q;
          state_n  = ST_MUL;
        end
      end
      ST_MUL: begin
        if (mm_done) begin
          s_n    = kept;
          ks_adv = 1'b1;
          if (ks_last) begin
            res_n   = kept;
            done_n  = 1'b1;
            state_n = ST_IDLE;
          end else begin
            mm_start = 1'b1;
            mm_a     = kept;
            mm_b     = kept;
            state_n  = ST_SQR;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      s_q     <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      s_q     <= s_n;
      done_q  <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= '0;
      n_q <= '0;
    end else if (accept) begin
      m_q <= m_n;
      n_q <= n_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (done_n) res_q <= res_n;
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign s_o    = res_q;

  // Checker counters: cycles and multiplies since the accepted start.
  logic [31:0] chk_lat_q;
  logic [15:0] chk_ops_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_lat_q <= '0;
      chk_ops_q <= '0;
    end else if (accept) begin
      chk_lat_q <= '0;
      chk_ops_q <= '0;
    end else if (busy_o) begin
      chk_lat_q <= chk_lat_q + 1'b1;
      if (mm_start) chk_ops_q <= chk_ops_q + 1'b1;
    end
  end

  // R3
  run_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (chk_lat_q == 32'(LAT)));

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R5
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R9
  mul_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (chk_ops_q == 16'(2 * WIDTH)));

  // R9
  back_to_square_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MUL && mm_done && !ks_last) |=> (state_q == ST_SQR));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(s_o));

  // R6
  in_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(m_q) && $stable(n_q)));

endmodule

// File: tb/ctexp_engine_bench.sv
module ctexp_engine_bench;

  localparam int W   = 32;
  localparam int LAT = 2 * W * (W + 1) + 1;
  localparam int NV  = 8;

  // {base, exponent, modulus}
  localparam logic [3*W-1:0] VECS [0:NV-1] = '{
    {32'd2,          32'd10,         32'd1000},
    {32'd0,          32'd5,          32'd7},
    {32'd3,          32'd0,          32'd7},
    {32'd5,          32'd1,          32'd13},
    {32'hFFFF_FFFA,  32'hFFFF_FFFF,  32'hFFFF_FFFB},
    {32'h1234_5678,  32'h9ABC_DEF1,  32'hFFFF_FFF1},
    {32'd7,          32'h8000_0000,  32'h8000_000B},
    {32'd1,          32'hDEAD_BEEF,  32'd2}
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i;
  logic [W-1:0] m_i, d_i, n_i;
  logic         busy_o, done_o;
  logic [W-1:0] s_o;

  int tests  = 0;
  int failed = 0;
  logic [W-1:0] last_res = '0;

  always #2 clk = ~clk;

  ctexp_engine #(.WIDTH(W)) u_ctexp_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .m_i     (m_i),
    .d_i     (d_i),
    .n_i     (n_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .s_o     (s_o)
  );

  function automatic logic [W-1:0] ref_pow(logic [W-1:0] m, logic [W-1:0] d,
                                           logic [W-1:0] n);
    logic [63:0] s;
    s = 64'd1;
    for (int j = W - 1; j >= 0; j--) begin
      s = (s * s) % {32'd0, n};
      if (d[j]) s = (s * {32'd0, m}) % {32'd0, n};
    end
    return s[W-1:0];
  endfunction

  task automatic check(input logic ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One run; disturb injects a start and changes operands mid-run.
  task automatic do_run(input logic [W-1:0] m, input logic [W-1:0] d,
                        input logic [W-1:0] n, input logic disturb,
                        output logic [W-1:0] res, output int lat);
    @(negedge clk);
    m_i = m; d_i = d; n_i = n; start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    check(busy_o == 1'b1, "R5 busy after start", 64'(busy_o), 64'd1);
    lat = 0;
    while (!done_o && lat < 5000) begin
      @(posedge clk); #1;
      lat++;
      if (lat == 1000)
        check(s_o == last_res, "R7 result held during run", 64'(s_o), 64'(last_res));
      if (disturb && lat == 300) begin
        start_i = 1'b1; m_i = 32'd3; d_i = 32'd3; n_i = 32'd11;
      end
      if (disturb && lat == 301) start_i = 1'b0;
      if (disturb && lat == 700) begin
        m_i = ~m; d_i = ~d; n_i = 32'd5;
      end
      if (!done_o && lat > 1 && lat < LAT && !busy_o)
        check(1'b0, "R5 busy dropped early", 64'(busy_o), 64'd1);
    end
    res = s_o;
    check(busy_o == 1'b0, "R5 busy low with done", 64'(busy_o), 64'd0);
    @(posedge clk); #1;
    check(done_o == 1'b0, "R4 done lasts one cycle", 64'(done_o), 64'd0);
    last_res = res;
  endtask

  initial begin
    #(4 * 150000);
    failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    logic [W-1:0] res, exp_v, hold;
    int lat;
    rst_n = 1'b0; start_i = 1'b0; m_i = '0; d_i = '0; n_i = '0;
    #10;
    // R1 reset state
    check(busy_o == 1'b0 && done_o == 1'b0 && s_o == '0, "R1 reset state",
          {31'd0, busy_o, done_o, s_o}, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check(busy_o == 1'b0 && done_o == 1'b0 && s_o == '0, "R1 after release",
          {31'd0, busy_o, done_o, s_o}, 64'd0);

    // Vector table: R2 results, R3/R9 fixed latency for every exponent
    for (int i = 0; i < NV; i++) begin
      logic [W-1:0] vm, vd, vn;
      {vm, vd, vn} = VECS[i];
      exp_v = ref_pow(vm, vd, vn);
      do_run(vm, vd, vn, 1'b0, res, lat);
      check(res == exp_v, "R2 result", 64'(res), 64'(exp_v));
      check(lat == LAT, "R3 latency", 64'(lat), 64'(LAT));
    end

    // R6 and R10: start pulse and operand changes while busy are ignored
    exp_v = ref_pow(32'd123457, 32'hC0DE_0001, 32'hFFFF_FF00);
    do_run(32'd123457, 32'hC0DE_0001, 32'hFFFF_FF00, 1'b1, res, lat);
    check(res == exp_v, "R6 R10 result unaffected", 64'(res), 64'(exp_v));
    check(lat == LAT, "R6 latency unaffected", 64'(lat), 64'(LAT));

    // R7: no start, inputs wiggle, result held
    hold = s_o;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); m_i = 32'(k); d_i = 32'(k * 3); n_i = 32'(k + 2);
    end
    #1;
    check(s_o == hold && !busy_o, "R7 result held when idle", 64'(s_o), 64'(hold));

    // R1: reset in the middle of a run aborts it
    @(negedge clk);
    m_i = 32'd9; d_i = 32'hFFFF; n_i = 32'd101; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (50) @(posedge clk);
    #1 rst_n = 1'b0;
    #1;
    check(busy_o == 1'b0 && done_o == 1'b0 && s_o == '0, "R1 mid-run reset",
          {31'd0, busy_o, done_o, s_o}, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    last_res = '0;
    repeat (LAT + 20) @(posedge clk);
    #1;
    check(done_o == 1'b0 && busy_o == 1'b0 && s_o == '0, "R1 aborted run stays idle",
          {31'd0, busy_o, done_o, s_o}, 64'd0);

    // R2 after reset recovery, exponent 0 boundary
    do_run(32'd4, 32'd0, 32'd5, 1'b0, res, lat);
    check(res == 32'd1, "R2 zero exponent", 64'(res), 64'd1);

    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

endmodule